// File: doc/BRIEF.md
# Selectable-Interval Watchdog Timer

This block watches for runaway software. Software writes a small mode register and an interval-select register over a plain write port, then arms the watchdog with a start bit. From then on, software must write that start bit again before the selected interval runs out. Each such write clears the watchdog count and begins a new interval. If the interval runs out, the block emits a one-cycle request on one of two outputs, system reset or non-maskable interrupt. A routing bit in the mode register picks the output.

Timing comes from a free-running main-clock prescaler. The watchdog counter counts the prescaler's ticks. A restart clears only the watchdog counter and never the prescaler. The first interval after a restart can therefore be short by up to one prescaler period. With the default widths that is 256 cycles, about 0.8% of the 2^15 interval. Counting continues while the halt input is high. Both the prescaler and the counter freeze while the stop input is high or while the subsystem-clock flag is set. Once armed, the configuration is locked until the next reset.

Top module: `wdt_loopguard`

## Requirements
- R1: After reset both request outputs are low. Before a start write, no request is raised, whatever time passes.
- R2: A write to the mode register (`wr_sel`=0) with bit 7 set starts the watchdog. The start write also clears the watchdog count.
- R3: Interval-select bits [2:1] (`wr_sel`=1) pick the interval as 2^(MIN_LOG+STEP_LOG*code) clock cycles. With the defaults this gives 2^11, 2^13, 2^15 and 2^17 cycles for values 000, 010, 100 and 110. Bit 0 is ignored, so an odd value acts like the even value below it. An unserviced watchdog fires again exactly one interval after each request.
- R4: The first request after a start or restart write comes between interval-2^PRE_LOG+1 and interval clock edges after the write edge. This is because the prescaler is never cleared.
- R5: Each later mode write with bit 7 set clears the count again. Rewriting it more often than the interval prevents any request.
- R6: When mode bit 3 was 0 at start, expiry pulses `sys_rst_req_o`. When it was 1, expiry pulses `nmi_req_o`. Each request lasts exactly one cycle, and only one output fires.
- R7: If mode bit 4 (enable) is 0 in the start write, no request is ever raised.
- R8: `halt_i` has no effect on counting, and the request period is unchanged.
- R9: Each cycle with `stop_i` high freezes counting. A stop of S cycles inside an interval lengthens that interval by exactly S.
- R10: Each cycle with `sub_clk_i` high freezes counting, exactly like R9.
- R11: After the start, interval-select writes are ignored, and so are the enable and routing bits of mode writes, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode register, 1 interval-select register |
| wr_data | input | 8 | Write data |
| halt_i | input | 1 | CPU halted; counting continues |
| stop_i | input | 1 | CPU stopped; counting freezes |
| sub_clk_i | input | 1 | CPU runs from the subsystem clock; counting freezes |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The request outputs are the only place a fault inside the block can show. A wrong prescaler or counter value shows up as a request period that is off by a countable number of cycles, and this appears within one interval. A lost clear shows up as a request during a run of timely restarts. A broken lock or routing latch shows up on the next expiry, either on the wrong output or after the wrong period. So every case is judged on exact request timing, or on a tight window measured from the write edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W      = 8;
  localparam int RUN_BIT     = 7;
  localparam int EN_BIT      = 4;
  localparam int ROUTE_BIT   = 3;
  localparam logic SEL_MODE  = 1'b0;
  localparam logic SEL_IVAL  = 1'b1;

  typedef struct packed {
    logic en;
    logic nmi;
  } wdt_mode_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_LOG = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  output logic tick_o
);
  logic [PRE_LOG-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (cnt_en) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = cnt_en & (&pre_q);

  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(pre_q)); // R10
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int CODE_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_sel,
  input  logic [wdt_pkg::DATA_W-1:0] wr_data,
  output wdt_pkg::wdt_mode_t         mode_o,
  output logic [CODE_W-1:0]          code_o,
  output logic                       started_o,
  output logic                       restart_o
);
  import wdt_pkg::*;

  wdt_mode_t         mode_q, mode_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              started_q, started_d;
  logic              mode_wr, ival_wr;
  logic              unused_bits;

  assign mode_wr = wr_en & (wr_sel == SEL_MODE);
  assign ival_wr = wr_en & (wr_sel == SEL_IVAL);
  assign unused_bits = ^{wr_data[DATA_W-1:CODE_W+1], wr_data[0]};

  always_comb begin
    mode_d    = mode_q;
    code_d    = code_q;
    started_d = started_q;
    if (!started_q) begin
      if (mode_wr) begin
        mode_d.en  = wr_data[EN_BIT];
        mode_d.nmi = wr_data[ROUTE_BIT];
        if (wr_data[RUN_BIT]) started_d = 1'b1;
      end
      if (ival_wr) code_d = wr_data[CODE_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      code_q    <= '0;
      started_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      code_q    <= code_d;
      started_q <= started_d;
    end
  end

  assign mode_o    = mode_q;
  assign code_o    = code_q;
  assign started_o = started_q;
  assign restart_o = mode_wr & wr_data[RUN_BIT];

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |=> started_q); // R11
  AST_LOCK_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |=> ($stable(code_q) && $stable(mode_q))); // R11
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
  parameter int MIN_LOG  = 11,
  parameter int STEP_LOG = 2,
  parameter int PRE_LOG  = 8,
  parameter int CODE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fire_o
);
  localparam int NCODES = 1 << CODE_W;
  localparam int BASE   = MIN_LOG - PRE_LOG;
  localparam int CNT_W  = BASE + STEP_LOG * (NCODES - 1);

  logic [CNT_W-1:0] tc_tab [NCODES];
  logic [CNT_W-1:0] wd_q, wd_d;
  logic             fire_q, fire_d;
  logic             at_tc, step;

  generate
    for (genvar g = 0; g < NCODES; g++) begin : g_tc
      localparam int SH = BASE + STEP_LOG * g;
      assign tc_tab[g] = CNT_W'((64'd1 << SH) - 64'd1);
    end
  endgenerate

  assign at_tc = (wd_q == tc_tab[code_i]);
  assign step  = run_i & tick_i & ~restart_i;

  always_comb begin
    wd_d   = wd_q;
    fire_d = 1'b0;
    if (restart_i) begin
      wd_d = '0;
    end else if (step) begin
      if (at_tc) begin
        wd_d   = '0;
        fire_d = 1'b1;
      end else begin
        wd_d = wd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q   <= '0;
      fire_q <= 1'b0;
    end else begin
      wd_q   <= wd_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o = fire_q;

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (wd_q == '0)); // R5
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i) |=> $stable(wd_q)); // R9
  AST_ONE_CYCLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q); // R6
  AST_FIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(run_i)); // R7
endmodule

// File: rtl/wdt_loopguard.sv
module wdt_loopguard #(
  parameter int MIN_LOG  = 11,
  parameter int STEP_LOG = 2,
  parameter int PRE_LOG  = 8,
  parameter int CODE_W   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       halt_i,
  input  logic       stop_i,
  input  logic       sub_clk_i,
  output logic       sys_rst_req_o,
  output logic       nmi_req_o
);
  import wdt_pkg::*;

  logic              rst_s_n;
  logic              cnt_en, tick, started, restart, fire, run;
  logic              unused_halt;
  wdt_mode_t         mode;
  logic [CODE_W-1:0] code;

  assign cnt_en      = ~stop_i & ~sub_clk_i;
  assign unused_halt = halt_i;
  assign run         = started & mode.en;

  wdt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  wdt_prescaler #(.PRE_LOG(PRE_LOG)) u_pre (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .cnt_en (cnt_en),
    .tick_o (tick)
  );

  wdt_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .mode_o    (mode),
    .code_o    (code),
    .started_o (started),
    .restart_o (restart)
  );

  wdt_interval #(
    .MIN_LOG  (MIN_LOG),
    .STEP_LOG (STEP_LOG),
    .PRE_LOG  (PRE_LOG),
    .CODE_W   (CODE_W)
  ) u_ival (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .run_i     (run),
    .restart_i (restart),
    .tick_i    (tick),
    .code_i    (code),
    .fire_o    (fire)
  );

  assign sys_rst_req_o = fire & ~mode.nmi;
  assign nmi_req_o     = fire &  mode.nmi;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    !started |-> !(sys_rst_req_o || nmi_req_o)); // R1
endmodule

// File: tb/tb_wdt_loopguard.sv
module tb_wdt_loopguard;
  localparam int MINL = 6;
  localparam int STEPL = 2;
  localparam int PREL = 3;
  localparam int PRE_P = 1 << PREL;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic halt_i = 1'b0, stop_i = 1'b0, sub_clk_i = 1'b0;
  logic sys_rst_req_o, nmi_req_o;

  int cyc = 0, errors = 0, checks = 0;
  int fire_cnt = 0, fire_cyc = 0, rst_cnt = 0, nmi_cnt = 0, wide_cnt = 0;
  logic prev_fire = 1'b0;

  always #2 clk = ~clk;

  wdt_loopguard #(.MIN_LOG(MINL), .STEP_LOG(STEPL), .PRE_LOG(PREL), .CODE_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .halt_i(halt_i), .stop_i(stop_i), .sub_clk_i(sub_clk_i),
    .sys_rst_req_o(sys_rst_req_o), .nmi_req_o(nmi_req_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sys_rst_req_o || nmi_req_o) begin
      fire_cnt <= fire_cnt + 1;
      fire_cyc <= cyc;
      if (sys_rst_req_o) rst_cnt <= rst_cnt + 1;
      if (nmi_req_o) nmi_cnt <= nmi_cnt + 1;
      if (prev_fire || (sys_rst_req_o && nmi_req_o)) wide_cnt <= wide_cnt + 1;
    end
    prev_fire <= sys_rst_req_o | nmi_req_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ival(input int code);
    return 1 << (MINL + STEPL * (code >> 1));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; halt_i = 1'b0; stop_i = 1'b0; sub_clk_i = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, output int at);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    at = cyc;
  endtask

  task automatic wait_fire(input int tmo, output bit got);
    int start;
    start = fire_cnt;
    got = 1'b0;
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk); #1;
      if (fire_cnt != start) begin got = 1'b1; break; end
    end
  endtask

  task automatic t_reset_idle();
    int at, n0;
    do_reset();
    check(!sys_rst_req_o && !nmi_req_o, "R1 outputs after reset", sys_rst_req_o + nmi_req_o, 0);
    n0 = fire_cnt;
    wr(1'b1, 8'h00, at);
    repeat (400) @(negedge clk);
    check(fire_cnt == n0, "R1 no request before start", fire_cnt - n0, 0);
  endtask

  task automatic t_interval(input int code);
    int at, f1, t;
    bit got;
    do_reset();
    wr(1'b1, 8'(code), at);
    wr(1'b0, 8'h90, at);
    t = ival(code);
    wait_fire(t + 50, got);
    f1 = fire_cyc;
    check(got && (f1 - at) >= t - PRE_P + 1 && (f1 - at) <= t,
          $sformatf("R2 R4 first expiry code %0d", code), f1 - at, t);
    wait_fire(t + 50, got);
    check(got && fire_cyc - f1 == t, $sformatf("R3 period code %0d", code), fire_cyc - f1, t);
  endtask

  task automatic t_route(input bit nmi);
    int at, r0, n0;
    bit got;
    do_reset();
    r0 = rst_cnt; n0 = nmi_cnt;
    wr(1'b0, nmi ? 8'h98 : 8'h90, at);
    wait_fire(200, got);
    repeat (2) @(negedge clk);
    check(got && (nmi_cnt - n0) == (nmi ? 1 : 0) && (rst_cnt - r0) == (nmi ? 0 : 1),
          $sformatf("R6 route nmi=%0d", nmi), nmi_cnt - n0, nmi ? 1 : 0);
  endtask

  task automatic t_restart();
    int at, n0;
    bit got;
    do_reset();
    wr(1'b0, 8'h90, at);
    n0 = fire_cnt;
    for (int i = 0; i < 20; i++) begin
      repeat (40) @(negedge clk);
      wr(1'b0, 8'h80, at);
    end
    check(fire_cnt == n0, "R5 restarts hold off request", fire_cnt - n0, 0);
    wait_fire(200, got);
    check(got && (fire_cyc - at) >= 64 - PRE_P + 1 && (fire_cyc - at) <= 64,
          "R4 R5 expiry after last restart", fire_cyc - at, 64);
  endtask

  task automatic t_disabled();
    int at, n0;
    do_reset();
    n0 = fire_cnt;
    wr(1'b0, 8'h80, at);
    repeat (400) @(negedge clk);
    check(fire_cnt == n0, "R7 disabled at start", fire_cnt - n0, 0);
  endtask

  task automatic t_freeze(input int which, input int hold);
    int at, f1, expv;
    bit got;
    do_reset();
    wr(1'b0, 8'h90, at);
    wait_fire(200, got);
    f1 = fire_cyc;
    repeat (10) @(negedge clk);
    if (which == 0) halt_i = 1'b1;
    if (which == 1) stop_i = 1'b1;
    if (which == 2) sub_clk_i = 1'b1;
    repeat (hold) @(negedge clk);
    if (which != 0) begin stop_i = 1'b0; sub_clk_i = 1'b0; end
    wait_fire(400, got);
    halt_i = 1'b0;
    expv = (which == 0) ? 64 : 64 + hold;
    if (which == 0) check(got && fire_cyc - f1 == expv, "R8 halt keeps period", fire_cyc - f1, expv);
    if (which == 1) check(got && fire_cyc - f1 == expv, "R9 stop freezes", fire_cyc - f1, expv);
    if (which == 2) check(got && fire_cyc - f1 == expv, "R10 subclock freezes", fire_cyc - f1, expv);
  endtask

  task automatic t_lock();
    int at, f1, r0;
    bit got;
    do_reset();
    wr(1'b0, 8'h90, at);
    wait_fire(200, got);
    f1 = fire_cyc;
    r0 = rst_cnt;
    wr(1'b1, 8'h06, at);
    wr(1'b0, 8'h08, at);
    wait_fire(400, got);
    check(got && fire_cyc - f1 == 64, "R11 period locked", fire_cyc - f1, 64);
    check(rst_cnt - r0 == 1, "R11 route locked", rst_cnt - r0, 1);
  endtask

  initial begin
    t_reset_idle();
    t_interval(0);
    t_interval(2);
    t_interval(4);
    t_interval(6);
    t_interval(3);
    t_interval(7);
    t_route(1'b0);
    t_route(1'b1);
    t_restart();
    t_disabled();
    t_freeze(0, 30);
    t_freeze(1, 30);
    t_freeze(2, 25);
    t_lock();
    check(wide_cnt == 0, "R6 single-cycle exclusive pulses", wide_cnt, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule